// File: doc/BRIEF.md
# Dual-Mode Event Counter/Timer

This block is a 16-bit counter/timer that advances either on a timing tick or on falling edges of an external event pin. The timing tick is either every system clock cycle or one of four slower ticks: the system clock divided by 12, 4 or 48, or the rising edges of a slow external clock input divided by 8. Four counting shapes are available, selected by a mode field:

- a 13-bit counter;
- a 16-bit counter;
- an 8-bit counter that reloads itself from the high byte;
- a split arrangement of two independent 8-bit counters.

Software drives the block through a small byte-wide write port. Address 0 holds the control byte, address 1 the low count byte, address 2 the high count byte, and address 3 is a flag-clear strobe. Both count bytes can be read at any time on output ports. Sticky overflow flags report wraps until software clears them. The event pin and the external clock are asynchronous and pass through two-flop synchronizers before edge detection, so each level must be held for at least two system clock cycles. Events are counted reliably up to a quarter of the system clock rate.

Top module: `evt_timer`

## Requirements
- R1: After reset both count bytes read 0x00, both overflow flags are 0, and the control byte is 0x00 (counting stopped).
- R2: A write to address 1 (low byte) or address 2 (high byte) shows on the count outputs at the next clock edge. It overrides an increment of that byte in the same cycle.
- R3: Mode field (control bits [1:0]) = 01 selects a 16-bit counter {high,low}. With control bit 3 = 1 the tick is every system clock cycle. The wrap from 0xFFFF to 0x0000 sets the overflow flag.
- R4: Mode 00 selects a 13-bit counter. Only low bits [4:0] count, and their carry increments the high byte. Low bits [7:5] keep their value. The wrap from high 0xFF / low[4:0] 0x1F to zero sets the overflow flag.
- R5: Mode 10 counts the low byte only. When the low byte is 0xFF, a tick loads it with the high byte and sets the overflow flag. The high byte is unchanged.
- R6: Mode 11 makes two 8-bit counters. The low byte uses the selected tick, is gated by control bit 6 and sets the overflow flag. The high byte always uses the timing tick, is gated by control bit 7 and sets the second overflow flag.
- R7: Overflow flags stay set until a write to address 3 with bit 0 (first flag) or bit 1 (second flag) set. A wrap in the same cycle as the clear leaves the flag set.
- R8: With the run bit (control bit 6) at 0, the count bytes do not change.
- R9: With control bit 3 = 0, the scale field (control bits [5:4]) selects the tick: 00 = system clock / 12, 01 = / 4, 10 = / 48.
- R10: Scale 11 ticks once per 8 synchronized rising edges of the external clock input.
- R11: With control bit 2 = 1, the counter advances once per falling edge of the event pin. The edge is counted within four clock cycles after the pin goes low, when each level is held at least two cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 low byte, 2 high byte, 3 flag clear |
| wr_data | input | 8 | Write data |
| evt_pin | input | 1 | Asynchronous event input, counted on falling edges |
| ext_clk | input | 1 | Asynchronous slow external clock for scale 11 |
| cnt_lo | output | 8 | Low count byte |
| cnt_hi | output | 8 | High count byte |
| ovf_flag | output | 1 | Sticky overflow flag of the main counter (low byte in split mode) |
| ovf_hi_flag | output | 1 | Sticky overflow flag of the high byte in split mode |

## Verification
The hardest case to reach from the ports is a wrap that lands in the same cycle as a flag clear or a byte write, because software cannot see the tick phase. The stimulus sidesteps this by running the counter from the system clock tick with an exact, edge-counted run window. It preloads the count bytes just below the wrap point, so the overflow falls on a chosen edge. The prescaled ticks are free-running with an unknown phase. They are checked over run windows that are whole multiples of the divisor, and in any such window the tick count is exact whatever the phase. Random runs of up to 600 cycles in the first three modes, with high bytes biased toward 0xFF, are compared against a stepping model in the bench.

// File: rtl/evt_timer_pkg.sv
// Package: shared types and register addresses for the event counter/timer.
package evt_timer_pkg;

    typedef enum logic [1:0] {
        MODE_13     = 2'b00,
        MODE_16     = 2'b01,
        MODE_RELOAD = 2'b10,
        MODE_SPLIT  = 2'b11
    } tmr_mode_e;

    // Control byte layout, MSB first
    typedef struct packed {
        logic       run_hi;   // [7] split-mode high byte run
        logic       run;      // [6] main run
        logic [1:0] scale;    // [5:4] prescale select
        logic       fast;     // [3] 1: system clock tick
        logic       evt_cnt;  // [2] 1: count event pin edges
        tmr_mode_e  mode;     // [1:0]
    } tmr_ctrl_t;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_LO   = 2'd1;
    localparam logic [1:0] ADDR_HI   = 2'd2;
    localparam logic [1:0] ADDR_CLR  = 2'd3;

endpackage

// File: rtl/evt_timer_sync_edge.sv
// Two-flop synchronizer plus edge detector for an asynchronous input.
// Assumes the input holds each level for at least two clock cycles.
// RISING=1 flags low-to-high transitions, otherwise high-to-low.
module evt_timer_sync_edge #(
    parameter bit RISING = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic edge_pulse
);
    localparam logic IDLE = RISING ? 1'b0 : 1'b1;

    logic s1, s2, s3;

    // Synchronize and keep one delayed copy for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= IDLE;
            s2 <= IDLE;
            s3 <= IDLE;
        end else begin
            s1 <= din;
            s2 <= s1;
            s3 <= s2;
        end
    end

    // Edge flag from the synchronized pair
    always_comb edge_pulse = RISING ? (s2 & ~s3) : (s3 & ~s2);

    AST_EDGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        edge_pulse |=> !edge_pulse); // R11

endmodule

// File: rtl/evt_timer_prescaler.sv
// Free-running prescaler. tick[i] pulses once per divisor period for scale
// code i; tick[3] pulses once per EXT_DIV external-clock rising edges.
// Assumes ext_rise is a one-cycle synchronized pulse.
module evt_timer_prescaler #(
    parameter int DIV_S0  = 12,
    parameter int DIV_S1  = 4,
    parameter int DIV_S2  = 48,
    parameter int EXT_DIV = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ext_rise,
    output logic [3:0] tick
);
    localparam int EXT_W = $clog2(EXT_DIV);

    genvar gi;
    generate
        for (gi = 0; gi < 3; gi++) begin : g_div
            localparam int D = (gi == 0) ? DIV_S0 : (gi == 1) ? DIV_S1 : DIV_S2;
            localparam int W = $clog2(D);
            logic [W-1:0] cnt;

            // Count system cycles modulo the divisor
            always_ff @(posedge clk) begin
                if (!rst_n)                       cnt <= '0;
                else if (cnt == W'(D - 1))        cnt <= '0;
                else                              cnt <= cnt + W'(1);
            end

            always_comb tick[gi] = (cnt == W'(D - 1));
        end
    endgenerate

    logic [EXT_W-1:0] ext_cnt;

    // Count external rising edges modulo EXT_DIV
    always_ff @(posedge clk) begin
        if (!rst_n)        ext_cnt <= '0;
        else if (ext_rise) ext_cnt <= ext_cnt + EXT_W'(1);
    end

    always_comb tick[3] = ext_rise && (ext_cnt == EXT_W'(EXT_DIV - 1));

    generate
        if ((DIV_S2 % DIV_S0 == 0) && (DIV_S2 % DIV_S1 == 0)) begin : g_align
            AST_DIV_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
                tick[2] |-> (tick[0] && tick[1])); // R9
        end
    endgenerate

endmodule

// File: rtl/evt_timer_core.sv
// Count register pair with mode decode, reload and sticky overflow flags.
// Assumes tick inputs are single-cycle pulses; writes beat increments.
module evt_timer_core
    import evt_timer_pkg::*;
#(
    parameter bit SPLIT_EN = 1'b1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  tmr_mode_e mode,
    input  logic      run_lo,
    input  logic      run_hi,
    input  logic      tick_lo,
    input  logic      tick_hi,
    input  logic      wr_lo,
    input  logic      wr_hi,
    input  logic [7:0] wdata,
    input  logic      clr_ovf,
    input  logic      clr_ovf_hi,
    output logic [7:0] lo,
    output logic [7:0] hi,
    output logic      ovf,
    output logic      ovf_hi
);
    logic       inc_lo, inc_hi;
    logic [7:0] nlo, nhi;
    logic       set_ovf, set_ovf_hi;

    always_comb inc_lo = run_lo && tick_lo;
    always_comb inc_hi = run_hi && tick_hi;

    // Next count and overflow events per mode, writes override last
    always_comb begin
        nlo        = lo;
        nhi        = hi;
        set_ovf    = 1'b0;
        set_ovf_hi = 1'b0;
        unique case (mode)
            MODE_13: if (inc_lo) begin
                nlo = {lo[7:5], lo[4:0] + 5'd1};
                if (lo[4:0] == 5'h1F) begin
                    nhi     = hi + 8'd1;
                    set_ovf = (hi == 8'hFF);
                end
            end
            MODE_16: if (inc_lo) begin
                {nhi, nlo} = {hi, lo} + 16'd1;
                set_ovf    = ({hi, lo} == 16'hFFFF);
            end
            MODE_RELOAD: if (inc_lo) begin
                if (lo == 8'hFF) begin
                    nlo     = hi;
                    set_ovf = 1'b1;
                end else begin
                    nlo = lo + 8'd1;
                end
            end
            MODE_SPLIT: if (SPLIT_EN) begin
                if (inc_lo) begin
                    nlo     = lo + 8'd1;
                    set_ovf = (lo == 8'hFF);
                end
                if (inc_hi) begin
                    nhi        = hi + 8'd1;
                    set_ovf_hi = (hi == 8'hFF);
                end
            end
            default: ;
        endcase
        if (wr_lo) nlo = wdata;
        if (wr_hi) nhi = wdata;
    end

    // Register counts and sticky flags; a wrap beats a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo     <= '0;
            hi     <= '0;
            ovf    <= 1'b0;
            ovf_hi <= 1'b0;
        end else begin
            lo     <= nlo;
            hi     <= nhi;
            ovf    <= set_ovf    ? 1'b1 : (clr_ovf    ? 1'b0 : ovf);
            ovf_hi <= set_ovf_hi ? 1'b1 : (clr_ovf_hi ? 1'b0 : ovf_hi);
        end
    end

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (lo == $past(wdata))); // R2
    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_lo && !run_hi && !wr_lo && !wr_hi) |=> ($stable(lo) && $stable(hi))); // R8
    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RELOAD && inc_lo && lo == 8'hFF && !wr_lo && !wr_hi)
        |=> (lo == $past(hi) && ovf)); // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr_ovf) |=> ovf); // R7
    AST_WRAP_16: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_16 && inc_lo && lo == 8'hFF && hi == 8'hFF && !wr_lo && !wr_hi)
        |=> (lo == 8'h00 && hi == 8'h00 && ovf)); // R3

endmodule

// File: rtl/evt_timer.sv
// Top of the event counter/timer: control register, write decode, input
// synchronizers, tick selection and the count core.
// Assumes evt_pin and ext_clk are asynchronous and slow (>= 2 cycles/level).
module evt_timer
    import evt_timer_pkg::*;
#(
    parameter bit SPLIT_EN = 1'b1,
    parameter int DIV_S0   = 12,
    parameter int DIV_S1   = 4,
    parameter int DIV_S2   = 48,
    parameter int EXT_DIV  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       evt_pin,
    input  logic       ext_clk,
    output logic [7:0] cnt_lo,
    output logic [7:0] cnt_hi,
    output logic       ovf_flag,
    output logic       ovf_hi_flag
);
    tmr_ctrl_t  ctrl;
    logic       wr_ctrl, wr_lo, wr_hi, wr_clr;
    logic       evt_fall, ext_rise;
    logic [3:0] presc_tick;
    logic       timer_tick, sel_tick;

    // Decode the write address
    always_comb begin
        wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);
        wr_lo   = wr_en && (wr_addr == ADDR_LO);
        wr_hi   = wr_en && (wr_addr == ADDR_HI);
        wr_clr  = wr_en && (wr_addr == ADDR_CLR);
    end

    // Hold the control byte
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl <= '0;
        else if (wr_ctrl) ctrl <= tmr_ctrl_t'(wr_data);
    end

    evt_timer_sync_edge #(.RISING(1'b0)) u_evt_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .din        (evt_pin),
        .edge_pulse (evt_fall)
    );

    evt_timer_sync_edge #(.RISING(1'b1)) u_ext_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .din        (ext_clk),
        .edge_pulse (ext_rise)
    );

    evt_timer_prescaler #(
        .DIV_S0  (DIV_S0),
        .DIV_S1  (DIV_S1),
        .DIV_S2  (DIV_S2),
        .EXT_DIV (EXT_DIV)
    ) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_rise (ext_rise),
        .tick     (presc_tick)
    );

    // Pick timing tick, then event or timing source for the main counter
    always_comb begin
        timer_tick = ctrl.fast ? 1'b1 : presc_tick[ctrl.scale];
        sel_tick   = ctrl.evt_cnt ? evt_fall : timer_tick;
    end

    evt_timer_core #(.SPLIT_EN(SPLIT_EN)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (ctrl.mode),
        .run_lo     (ctrl.run),
        .run_hi     (ctrl.run_hi && (ctrl.mode == MODE_SPLIT)),
        .tick_lo    (sel_tick),
        .tick_hi    (timer_tick),
        .wr_lo      (wr_lo),
        .wr_hi      (wr_hi),
        .wdata      (wr_data),
        .clr_ovf    (wr_clr && wr_data[0]),
        .clr_ovf_hi (wr_clr && wr_data[1]),
        .lo         (cnt_lo),
        .hi         (cnt_hi),
        .ovf        (ovf_flag),
        .ovf_hi     (ovf_hi_flag)
    );

    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && wr_data[1] && ctrl.mode != MODE_SPLIT) |=> !ovf_hi_flag); // R7

endmodule

// File: tb/evt_timer_test.sv
module evt_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       evt_pin = 1'b1;
    logic       ext_clk = 1'b0;
    logic [7:0] cnt_lo, cnt_hi;
    logic       ovf_flag, ovf_hi_flag;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    evt_timer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .evt_pin(evt_pin), .ext_clk(ext_clk),
        .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
        .ovf_flag(ovf_flag), .ovf_hi_flag(ovf_hi_flag)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] cbyte(input logic [1:0] m, input logic evt,
                                         input logic fast, input logic [1:0] sc,
                                         input logic run, input logic runh);
        return {runh, run, sc, fast, evt, m};
    endfunction

    // Called at a negedge; the write is captured at the next posedge
    task automatic do_write(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic preload(input logic [7:0] lo, input logic [7:0] hi);
        do_write(2'd1, lo);
        do_write(2'd2, hi);
        do_write(2'd3, 8'h03);
    endtask

    // Run for exactly k count-enabled edges (k >= 1)
    task automatic run_k(input logic [7:0] c, input int k);
        do_write(2'd0, c);
        repeat (k - 1) @(negedge clk);
        do_write(2'd0, c & 8'h3F);
    endtask

    // Reference model: k ticks in modes 13/16/reload
    task automatic model(input logic [1:0] m, input int k, inout logic [7:0] lo,
                         inout logic [7:0] hi, inout logic ov);
        for (int i = 0; i < k; i++) begin
            case (m)
                2'b00: begin
                    if (lo[4:0] == 5'h1F) begin
                        if (hi == 8'hFF) ov = 1'b1;
                        hi = hi + 8'd1;
                    end
                    lo[4:0] = lo[4:0] + 5'd1;
                end
                2'b01: begin
                    if ({hi, lo} == 16'hFFFF) ov = 1'b1;
                    {hi, lo} = {hi, lo} + 16'd1;
                end
                default: begin
                    if (lo == 8'hFF) begin lo = hi; ov = 1'b1; end
                    else lo = lo + 8'd1;
                end
            endcase
        end
    endtask

    initial begin
        int wd = 0;
        while (!done && wd < 150000) begin
            @(posedge clk);
            wd++;
        end
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] elo, ehi;
        logic       eov;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 lo", cnt_lo, 8'h00);
        check("R1 hi", cnt_hi, 8'h00);
        check("R1 flags", {ovf_flag, ovf_hi_flag}, 2'b00);

        // R10 external clock /8: 16 rising edges give 2 ticks
        do_write(2'd0, cbyte(2'b01, 0, 0, 2'b11, 1, 0));
        for (int i = 0; i < 16; i++) begin
            ext_clk = 1'b1; repeat (2) @(negedge clk);
            ext_clk = 1'b0; repeat (2) @(negedge clk);
        end
        repeat (6) @(negedge clk);
        do_write(2'd0, 8'h00);
        check("R10 ext div8", {cnt_hi, cnt_lo}, 16'd2);

        // R11 event edges
        preload(8'h00, 8'h00);
        do_write(2'd0, cbyte(2'b01, 1, 0, 2'b00, 1, 0));
        for (int i = 0; i < 5; i++) begin
            evt_pin = 1'b0; repeat (3) @(negedge clk);
            evt_pin = 1'b1; repeat (3) @(negedge clk);
        end
        evt_pin = 1'b0; repeat (4) @(negedge clk);
        check("R11 edge latency", {cnt_hi, cnt_lo}, 16'd6);
        evt_pin = 1'b1; repeat (4) @(negedge clk);
        do_write(2'd0, 8'h00);
        check("R11 event count", {cnt_hi, cnt_lo}, 16'd6);

        // R9 prescale selections
        preload(8'h00, 8'h00);
        run_k(cbyte(2'b01, 0, 0, 2'b01, 1, 0), 40);
        check("R9 div4", {cnt_hi, cnt_lo}, 16'd10);
        preload(8'h00, 8'h00);
        run_k(cbyte(2'b01, 0, 0, 2'b00, 1, 0), 48);
        check("R9 div12", {cnt_hi, cnt_lo}, 16'd4);
        preload(8'h00, 8'h00);
        run_k(cbyte(2'b01, 0, 0, 2'b10, 1, 0), 96);
        check("R9 div48", {cnt_hi, cnt_lo}, 16'd2);

        // R3 16-bit wrap
        preload(8'hFD, 8'hFF);
        run_k(cbyte(2'b01, 0, 1, 2'b00, 1, 0), 5);
        check("R3 wrap count", {cnt_hi, cnt_lo}, 16'h0002);
        check("R3 ovf", ovf_flag, 1'b1);

        // R7 sticky, then cleared
        repeat (5) @(negedge clk);
        check("R7 sticky", ovf_flag, 1'b1);
        do_write(2'd3, 8'h01);
        check("R7 cleared", ovf_flag, 1'b0);

        // R8 hold while stopped
        repeat (10) @(negedge clk);
        check("R8 hold", {cnt_hi, cnt_lo}, 16'h0002);

        // R4 13-bit mode
        preload(8'hFE, 8'hFF);
        run_k(cbyte(2'b00, 0, 1, 2'b00, 1, 0), 3);
        check("R4 lo", cnt_lo, 8'hE1);
        check("R4 hi", cnt_hi, 8'h00);
        check("R4 ovf", ovf_flag, 1'b1);

        // R5 reload mode
        preload(8'hFD, 8'hF0);
        run_k(cbyte(2'b10, 0, 1, 2'b00, 1, 0), 5);
        check("R5 lo", cnt_lo, 8'hF2);
        check("R5 hi", cnt_hi, 8'hF0);
        check("R5 ovf", ovf_flag, 1'b1);

        // R6 split mode, both halves running
        preload(8'hFE, 8'hFF);
        run_k(cbyte(2'b11, 0, 1, 2'b00, 1, 1), 3);
        check("R6 lo", cnt_lo, 8'h01);
        check("R6 hi", cnt_hi, 8'h02);
        check("R6 flags", {ovf_flag, ovf_hi_flag}, 2'b11);
        // R6 high half alone
        preload(8'h10, 8'h20);
        run_k(cbyte(2'b11, 0, 1, 2'b00, 0, 1), 4);
        check("R6 hi alone", {cnt_hi, cnt_lo}, 16'h2410);

        // R2 write wins over increment while running
        preload(8'h00, 8'h00);
        do_write(2'd0, cbyte(2'b01, 0, 1, 2'b00, 1, 0));
        repeat (3) @(negedge clk);
        do_write(2'd1, 8'h55);
        check("R2 lo write", cnt_lo, 8'h55);
        do_write(2'd2, 8'hA0);
        check("R2 hi write", cnt_hi, 8'hA0);
        do_write(2'd0, 8'h00);

        // R7 wrap in the cycle of a clear keeps the flag
        preload(8'hFF, 8'hFF);
        do_write(2'd0, cbyte(2'b01, 0, 1, 2'b00, 1, 0));
        do_write(2'd3, 8'h01);
        do_write(2'd0, 8'h00);
        check("R7 set beats clear", ovf_flag, 1'b1);

        // R3 R4 R5 random runs against the model
        for (int it = 0; it < 24; it++) begin
            logic [1:0] m;
            int k;
            m   = 2'($urandom_range(0, 2));
            elo = 8'($urandom_range(0, 255));
            ehi = ($urandom_range(0, 1) == 1) ? 8'(8'hFF - $urandom_range(0, 1))
                                              : 8'($urandom_range(0, 255));
            eov = 1'b0;
            k   = $urandom_range(1, 600);
            preload(elo, ehi);
            run_k(cbyte(m, 0, 1, 2'b00, 1, 0), k);
            model(m, k, elo, ehi, eov);
            check("R3/R4/R5 random lo", cnt_lo, elo);
            check("R3/R4/R5 random hi", cnt_hi, ehi);
            check("R3/R4/R5 random ovf", ovf_flag, eov);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule